// File: doc/BRIEF.md
# Configurable Overcurrent Fault Response Controller

This block watches an overcurrent detect input from the primary switch of an auxiliary converter. It chooses one of three reactions. The first only raises a flag. The second stops switching and restarts by itself once the fault has been gone for a set time. The third stops switching and stays off until the chip enable is cycled. In every mode the fault is recorded in a sticky status bit and shown on an active-low alert output. Software clears the bit with a write-one strobe.

The reaction comes from a 2-bit per-fault field when a global override bit is set, and from an external mode-pin setting when it is clear. When switching stops, the block gates both the primary converter enable and the downstream PWM channel enables. On recovery it brings the primary converter back first. After an automatic restart it then issues a one-cycle soft-start request to the PWM side. After a latched shutdown it waits for the PWM enable input to rise.

Top module: `ocp_fault_ctrl`

## Requirements
- R1: The effective response code decodes as 2'b00 = flag only, 2'b01 = auto-restart, 2'b10 = latch-off and 2'b11 = flag only.
- R2: With `indiv_en` = 1 the code is `resp_field`. With `indiv_en` = 0 the code is `mode_pin`, which uses the same encoding, and `resp_field` has no effect.
- R3: A cycle with `oc_det` high sets `stat_flag` to 1 and drives `alert_n` to 0 from the next cycle on. The flag stays set after `oc_det` falls.
- R4: If `stat_clr` is high in a cycle where `oc_det` is low, `stat_flag` clears and `alert_n` returns to 1 on the next cycle. If `oc_det` is high in that same cycle, the flag stays set.
- R5: In flag-only mode, `prim_sw_en` and `pwm_gate_en` stay 1 through a fault.
- R6: In auto-restart and latch-off modes, `oc_det` sampled while `prim_sw_en` is high drives `prim_sw_en` and `pwm_gate_en` to 0 on the next cycle.
- R7: In auto-restart, `prim_sw_en` returns to 1 after WAIT consecutive clock edges that sample `oc_det` low, where WAIT = CLK_HZ/1000*DELAY_MS. Any edge that samples `oc_det` high during the wait restarts the count.
- R8: In the cycle in which an auto-restart raises `prim_sw_en`, `pwm_ss_req` is 1 for exactly that cycle while `pwm_gate_en` stays 0. `pwm_gate_en` rises on the following cycle.
- R9: After a latch-off, `prim_sw_en` stays 0 regardless of `oc_det` until `chip_en` has been sampled low and then high. It rises on the cycle after `chip_en` is sampled high.
- R10: After a latch-off restart, `pwm_gate_en` stays 0 until an edge samples `pwm_en` high after having sampled it low on the previous edge. A level that is already high does not count.
- R11: After reset, `stat_flag` is 0, `alert_n` is 1, `prim_sw_en` and `pwm_gate_en` are 1, and `pwm_ss_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oc_det | input | 1 | Overcurrent detected on the primary switch |
| indiv_en | input | 1 | Global override: 1 selects resp_field, 0 selects mode_pin |
| resp_field | input | 2 | Per-fault response code |
| mode_pin | input | 2 | Response code from the external mode pin |
| chip_en | input | 1 | Chip enable; a low-then-high sequence clears latch-off |
| pwm_en | input | 1 | PWM enable; its rise releases PWM after a latch-off restart |
| stat_clr | input | 1 | Write-one-to-clear strobe for the status bit |
| stat_flag | output | 1 | Sticky overcurrent status bit |
| alert_n | output | 1 | Active-low alert, low while the status bit is set |
| prim_sw_en | output | 1 | Primary converter switching enable |
| pwm_gate_en | output | 1 | Enable for all downstream PWM channels |
| pwm_ss_req | output | 1 | One-cycle soft-start request to the PWM side |

## Verification
Every output is registered. The flag, the alert and the shutdown are due one edge after `oc_det` is sampled. The auto-restart raises `prim_sw_en` on the WAIT-th edge that samples the fault low. `pwm_gate_en` follows one edge after that, or one edge after the sampled `pwm_en` rise. The latch-off restart is due one edge after `chip_en` is sampled high again. The bench changes inputs just after a rising edge, advances a whole number of edges and samples one time unit after the edge. Every expected value is therefore taken at a fixed edge count from its stimulus. Edge counts of WAIT-1 and WAIT are both checked, so an off-by-one in the timer shows up.

// File: rtl/ocp_fault_ctrl.sv
module ocp_fault_ctrl #(
  parameter int CLK_HZ   = 250_000_000,
  parameter int DELAY_MS = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oc_det,
  input  logic       indiv_en,
  input  logic [1:0] resp_field,
  input  logic [1:0] mode_pin,
  input  logic       chip_en,
  input  logic       pwm_en,
  input  logic       stat_clr,
  output logic       stat_flag,
  output logic       alert_n,
  output logic       prim_sw_en,
  output logic       pwm_gate_en,
  output logic       pwm_ss_req
);
  localparam int WAIT = CLK_HZ / 1000 * DELAY_MS;
  localparam int CW   = $clog2(WAIT + 1);

  typedef enum logic [2:0] {S_RUN, S_WAIT, S_SS, S_LATCH, S_EN_LOW, S_PWM_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          pwm_en_q;
  logic          flag;

  wire [1:0] mode  = indiv_en ? resp_field : mode_pin;
  wire       m_hic = (mode == 2'b01);
  wire       m_lat = (mode == 2'b10);
  wire       live  = (st == S_RUN) || (st == S_SS) || (st == S_PWM_HOLD);

  assign stat_flag   = flag;
  assign alert_n     = ~flag;
  assign prim_sw_en  = live;
  assign pwm_gate_en = (st == S_RUN);
  assign pwm_ss_req  = (st == S_SS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_RUN;
      cnt      <= '0;
      pwm_en_q <= 1'b0;
      flag     <= 1'b0;
    end else begin
      flag     <= oc_det | (flag & ~stat_clr);
      pwm_en_q <= pwm_en;
      case (st)
        S_WAIT: begin
          if (oc_det)              cnt <= CW'(WAIT);
          else if (cnt == CW'(1))  st  <= S_SS;
          else                     cnt <= cnt - CW'(1);
        end
        S_LATCH:  if (!chip_en) st <= S_EN_LOW;
        S_EN_LOW: if (chip_en)  st <= S_PWM_HOLD;
        S_RUN, S_SS, S_PWM_HOLD: begin
          if (oc_det && m_hic) begin
            st  <= S_WAIT;
            cnt <= CW'(WAIT);
          end else if (oc_det && m_lat) begin
            st <= S_LATCH;
          end else if (st == S_SS) begin
            st <= S_RUN;
          end else if (st == S_PWM_HOLD && pwm_en && !pwm_en_q) begin
            st <= S_RUN;
          end
        end
        default: st <= S_RUN;
      endcase
    end
  end

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_det |=> (stat_flag && !alert_n));

  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !oc_det) |=> (!stat_flag && alert_n));

  // R5
  flag_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_det && !m_hic && !m_lat && pwm_gate_en) |=> (pwm_gate_en && prim_sw_en));

  // R6
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_det && (m_hic || m_lat) && prim_sw_en) |=> (!prim_sw_en && !pwm_gate_en));

  // R8
  ss_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_ss_req && !(oc_det && (m_hic || m_lat))) |=> (pwm_gate_en && !pwm_ss_req));

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LATCH && chip_en) |=> !prim_sw_en);
endmodule

// File: tb/ocp_fault_ctrl_test.sv
module ocp_fault_ctrl_test;
  localparam int CLK_HZ = 20_000;
  localparam int DLY    = 1;
  localparam int WAIT   = CLK_HZ / 1000 * DLY;

  logic clk = 0, rst_n = 0;
  logic oc_det = 0, indiv_en = 1, chip_en = 1, pwm_en = 1, stat_clr = 0;
  logic [1:0] resp_field = 2'b00, mode_pin = 2'b00;
  logic stat_flag, alert_n, prim_sw_en, pwm_gate_en, pwm_ss_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ocp_fault_ctrl #(.CLK_HZ(CLK_HZ), .DELAY_MS(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .oc_det(oc_det), .indiv_en(indiv_en),
    .resp_field(resp_field), .mode_pin(mode_pin), .chip_en(chip_en),
    .pwm_en(pwm_en), .stat_clr(stat_clr), .stat_flag(stat_flag),
    .alert_n(alert_n), .prim_sw_en(prim_sw_en), .pwm_gate_en(pwm_gate_en),
    .pwm_ss_req(pwm_ss_req));

  function automatic logic [1:0] exp_mode(logic ind, logic [1:0] f, logic [1:0] p);
    return ind ? f : p;
  endfunction

  function automatic logic exp_stops(logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic pulse_oc;
    oc_det = 1; tick(); oc_det = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    tick(2);
    // R11 reset state
    check("R11 flag", stat_flag, 0);
    check("R11 alert_n", alert_n, 1);
    check("R11 prim", prim_sw_en, 1);
    check("R11 pwm", pwm_gate_en, 1);
    check("R11 ss", pwm_ss_req, 0);
    rst_n = 1; tick();

    // R1 R5 flag-only with code 00 and 11
    resp_field = 2'b00; pulse_oc();
    check("R3 flag set", stat_flag, 1);
    check("R3 alert low", alert_n, 0);
    check("R5 prim 00", prim_sw_en, 1);
    check("R5 pwm 00", pwm_gate_en, 1);
    tick(3);
    check("R3 sticky", stat_flag, 1);
    resp_field = 2'b11; pulse_oc();
    check("R1 code 11 prim", prim_sw_en, 1);
    check("R1 code 11 pwm", pwm_gate_en, 1);

    // R4 set wins over clear, then clear
    oc_det = 1; stat_clr = 1; tick();
    check("R4 set priority", stat_flag, 1);
    oc_det = 0; tick();
    check("R4 cleared", stat_flag, 0);
    check("R4 alert high", alert_n, 1);
    stat_clr = 0;

    // R6 R7 R8 hiccup timing
    resp_field = 2'b01; pulse_oc();
    check("R6 prim off", prim_sw_en, 0);
    check("R6 pwm off", pwm_gate_en, 0);
    tick(WAIT - 1);
    check("R7 still off at WAIT-1", prim_sw_en, 0);
    tick();
    check("R7 prim back at WAIT", prim_sw_en, 1);
    check("R8 ss req", pwm_ss_req, 1);
    check("R8 pwm held", pwm_gate_en, 0);
    tick();
    check("R8 pwm on", pwm_gate_en, 1);
    check("R8 ss single", pwm_ss_req, 0);

    // R7 reload on reassert
    pulse_oc(); tick(10); pulse_oc();
    tick(WAIT - 1);
    check("R7 reload off", prim_sw_en, 0);
    tick();
    check("R7 reload on", prim_sw_en, 1);
    tick();

    // R9 R10 latch-off
    resp_field = 2'b10; pulse_oc();
    check("R6 latch off", prim_sw_en, 0);
    tick(WAIT + 10);
    check("R9 held off", prim_sw_en, 0);
    oc_det = 1; tick(3); oc_det = 0;
    chip_en = 0; tick();
    check("R9 en low", prim_sw_en, 0);
    chip_en = 1; tick();
    check("R9 restart", prim_sw_en, 1);
    check("R10 pwm held", pwm_gate_en, 0);
    tick(4);
    check("R10 high level ignored", pwm_gate_en, 0);
    pwm_en = 0; tick();
    check("R10 still held", pwm_gate_en, 0);
    pwm_en = 1; tick();
    check("R10 pwm on rise", pwm_gate_en, 1);

    // R2 override off: mode pin rules, field ignored
    indiv_en = 0; resp_field = 2'b01; mode_pin = 2'b00; pulse_oc();
    check("R2 field ignored", prim_sw_en, 1);
    resp_field = 2'b00; mode_pin = 2'b10; pulse_oc();
    check("R2 pin latch", prim_sw_en, 0);
    chip_en = 0; tick(); chip_en = 1; tick();
    pwm_en = 0; tick(); pwm_en = 1; tick();
    check("R10 pin path pwm", pwm_gate_en, 1);

    // R1 R2 random mode selection
    for (int i = 0; i < 40; i++) begin
      logic [1:0] m;
      indiv_en = 1'($urandom_range(0, 1));
      resp_field = 2'($urandom_range(0, 3));
      mode_pin = 2'($urandom_range(0, 3));
      m = exp_mode(indiv_en, resp_field, mode_pin);
      pulse_oc();
      check("R1 R2 random prim", prim_sw_en, !exp_stops(m));
      check("R3 random flag", stat_flag, 1);
      stat_clr = 1; tick(); stat_clr = 0;
      check("R4 random clear", stat_flag, 0);
      if (m == 2'b01) tick(WAIT + 1);
      else if (m == 2'b10) begin
        chip_en = 0; tick(); chip_en = 1; tick();
        pwm_en = 0; tick(); pwm_en = 1; tick();
      end
      check("R8 R10 random recovered", pwm_gate_en, 1);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule